// File: doc/BRIEF.md
# Snooping Four-State Coherent Cache Cluster

This block models a handful of small private caches that share one bus in front of a single internal memory array. Each processor port presents a read or a write and holds it until a one-cycle response returns with the data. Each cache is direct-mapped and holds one data word per line. Every line carries one of four states: Modified, Exclusive, Shared or Invalid. Hits are served inside the cache. Misses, upgrades and dirty evictions compete for the bus, and a round-robin arbiter grants it.

While one cache owns the bus, every other cache looks up the bus address in its own tags. A cache that holds the word Exclusive or Modified supplies the data in place of memory. A Modified holder also writes the word back in the same transaction. All holders then apply the state change the command asks for, at the moment the transaction completes. A transaction-complete strobe, together with the command code, the owner and a flag for "data came from a cache", is brought out so that bus traffic can be observed.

Top module: `mesi_coherent_mem`

## Requirements
- R1: After reset every line is Invalid, no response or transaction strobe is active, and memory word at address a holds (3*a+1) truncated to the data width.
- R2: A read miss that no other cache holds issues one transaction with command code 1 (read), is served from memory (supplied flag 0), and installs the line Exclusive, so a later write to it causes no transaction.
- R3: A read hit in any valid state, and a write hit on an Exclusive or Modified line, respond one cycle after the request is taken and cause no bus transaction.
- R4: A read whose address another cache holds Exclusive or Modified is supplied by that cache (supplied flag 1), and both copies end Shared. A Modified supplier also writes the word to memory, so a later read served from memory returns the updated value.
- R5: A write to a Shared line issues command code 3 (upgrade), and every other copy becomes Invalid, so the next read by a former holder goes to the bus.
- R6: A write miss issues command code 2 (read for ownership), invalidates all other copies and leaves the writer's line Modified.
- R7: For any address, a line held Modified or Exclusive by one cache is never valid in another cache.
- R8: The requesting cache installs a read as Shared when any other cache holds a valid copy, and as Exclusive otherwise.
- R9: Replacing a Modified line first issues command code 4 (writeback) and then the fill. Replacing an Exclusive or Shared line issues no writeback.
- R10: At most one transaction runs at a time, grants rotate round-robin, and every request that waits is eventually served. Each transaction-complete strobe lasts one cycle.
- R11: A memory write counts as complete only after memory returns its acknowledgement. A writeback transaction never completes before that acknowledgement.
- R12: Every read returns the value of the most recent completed write to that address (or the reset value), under any interleaving of ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | N_CACHE | Per-port request, held until the response |
| cpu_we_i | input | N_CACHE | Per-port write select |
| cpu_addr_i | input | N_CACHE*ADDR_W | Per-port word address; port c in slice c |
| cpu_wdata_i | input | N_CACHE*DATA_W | Per-port write data |
| cpu_resp_o | output | N_CACHE | One-cycle response strobe per port |
| cpu_rdata_o | output | N_CACHE*DATA_W | Read data (the written value for writes) |
| txn_done_o | output | 1 | Bus transaction completes this cycle |
| txn_cmd_o | output | 3 | Command of the current transaction: 1 read, 2 read for ownership, 3 upgrade, 4 writeback |
| txn_owner_o | output | $clog2(N_CACHE) | Index of the cache that owns the bus |
| txn_supplied_o | output | 1 | Data of the current transaction came from another cache |

## Verification
The bench uses the defaults: four caches of four lines, a 6-bit word address and 16-bit data. It confines the random sweep to sixteen addresses, so four tags fall on each line index. That makes conflict evictions, dirty writebacks, cache-to-cache supply and invalidations occur every few operations, and it lets a shadow memory predict every read value. A scripted sequence first walks each state transition with exact transaction counts and command codes. Rounds in which all four ports request in the same cycle then exercise arbitration and the snoop paths under contention.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;

    localparam logic [2:0] CMD_NONE = 3'd0;
    localparam logic [2:0] CMD_RD   = 3'd1;
    localparam logic [2:0] CMD_RDX  = 3'd2;
    localparam logic [2:0] CMD_UPGR = 3'd3;
    localparam logic [2:0] CMD_WB   = 3'd4;

    typedef enum logic [2:0] {B_IDLE, B_SNOOP, B_MEMR, B_MEMW, B_DONE} bus_ph_e;
    typedef enum logic {C_IDLE, C_BUS} cache_ph_e;
endpackage

// File: rtl/mesi_mem.sv
module mesi_mem #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          ack_o
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          ack;
    } mem_reg_t;

    mem_reg_t      r_d, r_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d   = mem_q;
        r_d     = r_q;
        r_d.ack = wr_en_i;
        if (rd_en_i) r_d.rdata = mem_q[addr_i];
        if (wr_en_i) mem_d[addr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(3 * i + 1);
            r_q <= '0;
        end else begin
            mem_q <= mem_d;
            r_q   <= r_d;
        end
    end

    assign rdata_o = r_q.rdata;
    assign ack_o   = r_q.ack;

    // R11: every memory write is acknowledged on the following cycle
    p_ack_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ack_o);
endmodule

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req_i,
    input  logic           take_i,
    output logic [N-1:0]   grant_o,
    output logic [IDW-1:0] gidx_o
);
    typedef struct packed {
        logic [IDW-1:0] ptr;
    } arb_reg_t;

    arb_reg_t       d, q;
    logic           found;
    logic [IDW-1:0] nxt;

    always_comb begin
        grant_o = '0;
        gidx_o  = '0;
        found   = 1'b0;
        nxt     = q.ptr;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(q.ptr) + k) % N;
            if (!found && req_i[idx]) begin
                found        = 1'b1;
                grant_o[idx] = 1'b1;
                gidx_o       = IDW'(idx);
                nxt          = IDW'((idx + 1) % N);
            end
        end
        d = q;
        if (take_i && found) d.ptr = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10: a single winner, and only among the requesters
    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    p_grant_requested_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);
endmodule

// File: rtl/mesi_bus.sv
module mesi_bus
    import mesi_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = 2,
    parameter int AW  = 6,
    parameter int DW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           req_i,
    input  logic [N-1:0][2:0]      req_cmd_i,
    input  logic [N-1:0][AW-1:0]   req_addr_i,
    input  logic [N-1:0][DW-1:0]   req_data_i,
    input  logic [N-1:0][1:0]      sn_st_i,
    input  logic [N-1:0][DW-1:0]   sn_data_i,
    output logic                   busy_o,
    output logic [AW-1:0]          addr_o,
    output logic [IDW-1:0]         owner_o,
    output logic [2:0]             cmd_o,
    output logic                   done_o,
    output logic                   shared_o,
    output logic                   supplied_o,
    output logic [DW-1:0]          data_o,
    output logic                   mem_rd_o,
    output logic                   mem_wr_o,
    output logic [AW-1:0]          mem_addr_o,
    output logic [DW-1:0]          mem_wdata_o,
    input  logic [DW-1:0]          mem_rdata_i,
    input  logic                   mem_ack_i
);
    typedef struct packed {
        bus_ph_e        ph;
        logic [IDW-1:0] owner;
        logic [2:0]     cmd;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic           shared;
        logic           supplied;
    } bus_reg_t;

    bus_reg_t       d, q;
    logic [N-1:0]   grant;
    logic [IDW-1:0] gidx;
    logic           take;
    logic           any_valid, sup_hit, sup_dirty;
    logic [DW-1:0]  sup_data;

    assign take = (q.ph == B_IDLE) && (|req_i);

    mesi_rr_arb #(.N(N), .IDW(IDW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .take_i  (take),
        .grant_o (grant),
        .gidx_o  (gidx)
    );

    // combine the snoop answers of every cache except the owner
    always_comb begin
        any_valid = 1'b0;
        sup_hit   = 1'b0;
        sup_dirty = 1'b0;
        sup_data  = '0;
        for (int c = 0; c < N; c++) begin
            if (IDW'(c) != q.owner) begin
                if (sn_st_i[c] != ST_I) any_valid = 1'b1;
                if (sn_st_i[c] == ST_E || sn_st_i[c] == ST_M) begin
                    sup_hit  = 1'b1;
                    sup_data = sn_data_i[c];
                    if (sn_st_i[c] == ST_M) sup_dirty = 1'b1;
                end
            end
        end
    end

    always_comb begin
        d           = q;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_wdata_o = q.data;
        case (q.ph)
            B_IDLE: begin
                if (|req_i) begin
                    d.owner    = gidx;
                    d.cmd      = req_cmd_i[gidx];
                    d.addr     = req_addr_i[gidx];
                    d.data     = req_data_i[gidx];
                    d.shared   = 1'b0;
                    d.supplied = 1'b0;
                    d.ph       = B_SNOOP;
                end
            end
            B_SNOOP: begin
                d.shared = any_valid;
                if (q.cmd == CMD_UPGR) begin
                    d.ph = B_DONE;
                end else if (q.cmd == CMD_WB) begin
                    mem_wr_o = 1'b1;
                    d.ph     = B_MEMW;
                end else if (sup_hit) begin
                    d.data     = sup_data;
                    d.supplied = 1'b1;
                    if (sup_dirty) begin
                        mem_wr_o    = 1'b1;
                        mem_wdata_o = sup_data;
                        d.ph        = B_MEMW;
                    end else begin
                        d.ph = B_DONE;
                    end
                end else begin
                    mem_rd_o = 1'b1;
                    d.ph     = B_MEMR;
                end
            end
            B_MEMR: begin
                d.data = mem_rdata_i;
                d.ph   = B_DONE;
            end
            B_MEMW: begin
                if (mem_ack_i) d.ph = B_DONE;
            end
            default: begin
                d.ph = B_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= B_IDLE;
            q.cmd   <= CMD_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.ph != B_IDLE);
    assign addr_o     = q.addr;
    assign owner_o    = q.owner;
    assign cmd_o      = q.cmd;
    assign done_o     = (q.ph == B_DONE);
    assign shared_o   = q.shared;
    assign supplied_o = q.supplied;
    assign data_o     = q.data;
    assign mem_addr_o = q.addr;

    // R10: completion strobe is a single cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11: a writeback completes only right after the memory acknowledgement
    p_wb_acked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cmd_o == CMD_WB) |-> $past(mem_ack_i));
endmodule

// File: rtl/mesi_cache.sv
module mesi_cache
    import mesi_pkg::*;
#(
    parameter int MY_ID = 0,
    parameter int IDW   = 2,
    parameter int LINES = 4,
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int IW    = $clog2(LINES),
    parameter int TW    = AW - IW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req_i,
    input  logic                     cpu_we_i,
    input  logic [AW-1:0]            cpu_addr_i,
    input  logic [DW-1:0]            cpu_wdata_i,
    output logic                     cpu_resp_o,
    output logic [DW-1:0]            cpu_rdata_o,
    output logic                     bus_req_o,
    output logic [2:0]               bus_cmd_o,
    output logic [AW-1:0]            bus_addr_o,
    output logic [DW-1:0]            bus_data_o,
    input  logic                     bus_busy_i,
    input  logic [AW-1:0]            bus_addr_i,
    input  logic [IDW-1:0]           bus_owner_i,
    input  logic [2:0]               bus_cmd_i,
    input  logic                     bus_done_i,
    input  logic                     bus_shared_i,
    input  logic [DW-1:0]            bus_data_i,
    output logic [1:0]               sn_st_o,
    output logic [DW-1:0]            sn_data_o,
    output logic [LINES-1:0][1:0]    lines_st_o,
    output logic [LINES-1:0][TW-1:0] lines_tag_o
);
    typedef struct packed {
        line_st_e [LINES-1:0]          st;
        logic     [LINES-1:0][TW-1:0]  tag;
        logic     [LINES-1:0][DW-1:0]  dat;
        cache_ph_e                     ph;
        logic                          resp;
        logic     [DW-1:0]             rdata;
    } cache_reg_t;

    cache_reg_t    d, q;
    logic [IW-1:0] idx, sidx;
    logic [TW-1:0] tg, stag;
    line_st_e      cur_st;
    logic          tag_hit, local_ok, blocked, mine_done, snoop_hit, victim_dirty;

    assign idx    = cpu_addr_i[IW-1:0];
    assign tg     = cpu_addr_i[AW-1:IW];
    assign sidx   = bus_addr_i[IW-1:0];
    assign stag   = bus_addr_i[AW-1:IW];
    assign cur_st = q.st[idx];

    always_comb begin
        tag_hit      = (cur_st != ST_I) && (q.tag[idx] == tg);
        local_ok     = tag_hit && (!cpu_we_i || cur_st == ST_E || cur_st == ST_M);
        blocked      = bus_busy_i && (bus_addr_i == cpu_addr_i);
        mine_done    = bus_done_i && (bus_owner_i == IDW'(MY_ID));
        snoop_hit    = (q.st[sidx] != ST_I) && (q.tag[sidx] == stag);
        victim_dirty = (cur_st == ST_M) && (q.tag[idx] != tg);
    end

    // bus request: dirty victim first, then the access itself
    always_comb begin
        bus_req_o  = (q.ph == C_BUS);
        bus_addr_o = cpu_addr_i;
        bus_data_o = q.dat[idx];
        if (victim_dirty) begin
            bus_cmd_o  = CMD_WB;
            bus_addr_o = {q.tag[idx], idx};
        end else if (cpu_we_i) begin
            bus_cmd_o = (tag_hit && cur_st == ST_S) ? CMD_UPGR : CMD_RDX;
        end else begin
            bus_cmd_o = CMD_RD;
        end
    end

    always_comb begin
        sn_st_o   = snoop_hit ? q.st[sidx] : ST_I;
        sn_data_o = q.dat[sidx];
    end

    always_comb begin
        d      = q;
        d.resp = 1'b0;
        // snooped transaction of another cache takes effect at completion
        if (bus_done_i && !mine_done && snoop_hit) begin
            if (bus_cmd_i == CMD_RD)
                d.st[sidx] = ST_S;
            else if (bus_cmd_i == CMD_RDX || bus_cmd_i == CMD_UPGR)
                d.st[sidx] = ST_I;
        end
        case (q.ph)
            C_IDLE: begin
                if (cpu_req_i && !q.resp && !blocked) begin
                    if (local_ok) begin
                        d.resp = 1'b1;
                        if (cpu_we_i) begin
                            d.st[idx]  = ST_M;
                            d.dat[idx] = cpu_wdata_i;
                            d.rdata    = cpu_wdata_i;
                        end else begin
                            d.rdata = q.dat[idx];
                        end
                    end else begin
                        d.ph = C_BUS;
                    end
                end
            end
            default: begin
                if (mine_done) begin
                    if (bus_cmd_i == CMD_WB) begin
                        d.st[idx] = ST_I;
                    end else begin
                        d.tag[idx] = tg;
                        d.resp     = 1'b1;
                        d.ph       = C_IDLE;
                        if (cpu_we_i) begin
                            d.st[idx]  = ST_M;
                            d.dat[idx] = cpu_wdata_i;
                            d.rdata    = cpu_wdata_i;
                        end else begin
                            d.st[idx]  = bus_shared_i ? ST_S : ST_E;
                            d.dat[idx] = bus_data_i;
                            d.rdata    = bus_data_i;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= C_IDLE;
            for (int l = 0; l < LINES; l++) q.st[l] <= ST_I;
        end else begin
            q <= d;
        end
    end

    assign cpu_resp_o  = q.resp;
    assign cpu_rdata_o = q.rdata;

    for (genvar l = 0; l < LINES; l++) begin : g_exp
        assign lines_st_o[l]  = q.st[l];
        assign lines_tag_o[l] = q.tag[l];
    end

    // R3: the response is a one-cycle pulse
    p_resp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_o |=> !cpu_resp_o);
    // R10: a waiting bus request stays raised until its own completion
    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !mine_done) |=> bus_req_o);
endmodule

// File: rtl/mesi_coherent_mem.sv
module mesi_coherent_mem
    import mesi_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int N_LINES = 4,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int IDW     = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CACHE-1:0]         cpu_req_i,
    input  logic [N_CACHE-1:0]         cpu_we_i,
    input  logic [N_CACHE*ADDR_W-1:0]  cpu_addr_i,
    input  logic [N_CACHE*DATA_W-1:0]  cpu_wdata_i,
    output logic [N_CACHE-1:0]         cpu_resp_o,
    output logic [N_CACHE*DATA_W-1:0]  cpu_rdata_o,
    output logic                       txn_done_o,
    output logic [2:0]                 txn_cmd_o,
    output logic [IDW-1:0]             txn_owner_o,
    output logic                       txn_supplied_o
);
    localparam int IW = $clog2(N_LINES);
    localparam int TW = ADDR_W - IW;

    logic [N_CACHE-1:0]                     c_req;
    logic [N_CACHE-1:0][2:0]                c_cmd;
    logic [N_CACHE-1:0][ADDR_W-1:0]         c_addr;
    logic [N_CACHE-1:0][DATA_W-1:0]         c_data;
    logic [N_CACHE-1:0][1:0]                sn_st;
    logic [N_CACHE-1:0][DATA_W-1:0]         sn_data;
    logic [N_CACHE-1:0][N_LINES-1:0][1:0]   line_st;
    logic [N_CACHE-1:0][N_LINES-1:0][TW-1:0] line_tag;

    logic              b_busy, b_done, b_shared, b_sup;
    logic [ADDR_W-1:0] b_addr;
    logic [IDW-1:0]    b_owner;
    logic [2:0]        b_cmd;
    logic [DATA_W-1:0] b_data;
    logic              m_rd, m_wr, m_ack;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_wdata, m_rdata;

    for (genvar c = 0; c < N_CACHE; c++) begin : g_cache
        mesi_cache #(
            .MY_ID (c),
            .IDW   (IDW),
            .LINES (N_LINES),
            .AW    (ADDR_W),
            .DW    (DATA_W)
        ) u_cache (
            .clk          (clk),
            .rst_n        (rst_n),
            .cpu_req_i    (cpu_req_i[c]),
            .cpu_we_i     (cpu_we_i[c]),
            .cpu_addr_i   (cpu_addr_i[c*ADDR_W +: ADDR_W]),
            .cpu_wdata_i  (cpu_wdata_i[c*DATA_W +: DATA_W]),
            .cpu_resp_o   (cpu_resp_o[c]),
            .cpu_rdata_o  (cpu_rdata_o[c*DATA_W +: DATA_W]),
            .bus_req_o    (c_req[c]),
            .bus_cmd_o    (c_cmd[c]),
            .bus_addr_o   (c_addr[c]),
            .bus_data_o   (c_data[c]),
            .bus_busy_i   (b_busy),
            .bus_addr_i   (b_addr),
            .bus_owner_i  (b_owner),
            .bus_cmd_i    (b_cmd),
            .bus_done_i   (b_done),
            .bus_shared_i (b_shared),
            .bus_data_i   (b_data),
            .sn_st_o      (sn_st[c]),
            .sn_data_o    (sn_data[c]),
            .lines_st_o   (line_st[c]),
            .lines_tag_o  (line_tag[c])
        );
    end

    mesi_bus #(.N(N_CACHE), .IDW(IDW), .AW(ADDR_W), .DW(DATA_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (c_req),
        .req_cmd_i   (c_cmd),
        .req_addr_i  (c_addr),
        .req_data_i  (c_data),
        .sn_st_i     (sn_st),
        .sn_data_i   (sn_data),
        .busy_o      (b_busy),
        .addr_o      (b_addr),
        .owner_o     (b_owner),
        .cmd_o       (b_cmd),
        .done_o      (b_done),
        .shared_o    (b_shared),
        .supplied_o  (b_sup),
        .data_o      (b_data),
        .mem_rd_o    (m_rd),
        .mem_wr_o    (m_wr),
        .mem_addr_o  (m_addr),
        .mem_wdata_o (m_wdata),
        .mem_rdata_i (m_rdata),
        .mem_ack_i   (m_ack)
    );

    mesi_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_i (m_rd),
        .wr_en_i (m_wr),
        .addr_i  (m_addr),
        .wdata_i (m_wdata),
        .rdata_o (m_rdata),
        .ack_o   (m_ack)
    );

    assign txn_done_o     = b_done;
    assign txn_cmd_o      = b_cmd;
    assign txn_owner_o    = b_owner;
    assign txn_supplied_o = b_sup;

    // R7: an owning copy (Exclusive or Modified) excludes every other valid copy
    for (genvar l = 0; l < N_LINES; l++) begin : g_chk_line
        for (genvar a = 0; a < N_CACHE; a++) begin : g_chk_a
            for (genvar b = 0; b < N_CACHE; b++) begin : g_chk_b
                if (a != b) begin : g_pair
                    p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
                        (line_st[a][l] == ST_M || line_st[a][l] == ST_E) |->
                        !(line_st[b][l] != ST_I && line_tag[b][l] == line_tag[a][l]));
                end
            end
        end
    end
endmodule

// File: tb/mesi_coherent_mem_tb.sv
module mesi_coherent_mem_tb;
    localparam int N  = 4;
    localparam int AW = 6;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]         req = '0, we = '0;
    logic [N-1:0][AW-1:0] addr = '0;
    logic [N-1:0][DW-1:0] wdata = '0;
    logic [N-1:0]         resp;
    logic [N-1:0][DW-1:0] rdata;
    logic                 t_done, t_sup;
    logic [2:0]           t_cmd;
    logic [1:0]           t_owner;

    mesi_coherent_mem u_dut (
        .clk (clk), .rst_n (rst_n),
        .cpu_req_i (req), .cpu_we_i (we), .cpu_addr_i (addr), .cpu_wdata_i (wdata),
        .cpu_resp_o (resp), .cpu_rdata_o (rdata),
        .txn_done_o (t_done), .txn_cmd_o (t_cmd), .txn_owner_o (t_owner),
        .txn_supplied_o (t_sup)
    );

    int errors = 0, checks = 0;
    int txn_cnt = 0, wb_cnt = 0;
    logic [2:0] last_cmd = '0;
    logic last_sup = 1'b0;
    logic [N-1:0] own_mask = '0;
    logic [DW-1:0] shadow [64];

    always @(negedge clk) begin
        if (rst_n && t_done) begin
            txn_cnt++;
            last_cmd = t_cmd;
            last_sup = t_sup;
            own_mask[t_owner] = 1'b1;
            if (t_cmd == 3'd4) wb_cnt++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input int c, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] v,
                      output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        req[c] = 1'b1; we[c] = w; addr[c] = a; wdata[c] = v;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!resp[c] && lat < 400);
        rd = rdata[c];
        req[c] = 1'b0;
        if (lat >= 400) chk("R10 op timeout", 0, 1);
        if (w) shadow[a] = v;
    endtask

    task automatic multi(input logic [N-1:0] w, input logic [N-1:0][AW-1:0] a,
                         input logic [N-1:0][DW-1:0] v, output logic [N-1:0][DW-1:0] rd);
        logic [N-1:0] pend;
        int t;
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
            req[c] = 1'b1; we[c] = w[c]; addr[c] = a[c]; wdata[c] = v[c];
        end
        pend = '1;
        t = 0;
        while (pend != '0 && t < 800) begin
            @(negedge clk);
            t++;
            for (int c = 0; c < N; c++) begin
                if (pend[c] && resp[c]) begin
                    rd[c] = rdata[c];
                    pend[c] = 1'b0;
                    req[c] = 1'b0;
                end
            end
        end
        req = '0;
        chk("R10 all concurrent requests served", pend, 0);
        for (int c = 0; c < N; c++) if (w[c]) shadow[a[c]] = v[c];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [N-1:0][DW-1:0] mrd;
        logic [N-1:0][AW-1:0] ma;
        logic [N-1:0][DW-1:0] mv;
        int lat, t0, w0;
        logic [31:0] s;

        for (int i = 0; i < 64; i++) shadow[i] = DW'(3 * i + 1);
        repeat (3) @(negedge clk);
        chk("R1 no response in reset", resp, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 no response after reset", resp, 0);
        chk("R1 no transaction after reset", t_done, 0);

        // a=5: read miss, nobody holds it
        t0 = txn_cnt;
        op(0, 0, 6'd5, 0, rd, lat);
        chk("R1 reset memory value", rd, 16);
        chk("R2 one read transaction", txn_cnt - t0, 1);
        chk("R2 command code read", last_cmd, 1);
        chk("R2 served from memory", last_sup, 0);
        t0 = txn_cnt;
        op(0, 0, 6'd5, 0, rd, lat);
        chk("R3 read hit latency", lat, 1);
        chk("R3 read hit no bus", txn_cnt - t0, 0);
        op(0, 1, 6'd5, 16'hAAAA, rd, lat);
        chk("R2 write to Exclusive is silent", txn_cnt - t0, 0);
        chk("R3 write hit latency", lat, 1);

        // modified holder supplies and writes back
        t0 = txn_cnt;
        op(1, 0, 6'd5, 0, rd, lat);
        chk("R4 data from Modified holder", rd, 16'hAAAA);
        chk("R4 supplied by cache", last_sup, 1);
        op(2, 0, 6'd5, 0, rd, lat);
        chk("R4 memory updated by flush", rd, 16'hAAAA);
        chk("R4 shared holders do not supply", last_sup, 0);
        t0 = txn_cnt;
        op(2, 1, 6'd5, 16'h1234, rd, lat);
        chk("R8 installed Shared so write upgrades", last_cmd, 3);
        chk("R5 upgrade is one transaction", txn_cnt - t0, 1);
        t0 = txn_cnt;
        op(0, 0, 6'd5, 0, rd, lat);
        chk("R5 invalidated copy refetches", txn_cnt - t0, 1);
        chk("R5 fresh value after invalidate", rd, 16'h1234);
        chk("R4 Modified holder supplies", last_sup, 1);
        op(1, 0, 6'd5, 0, rd, lat);
        chk("R5 second former holder refetches", rd, 16'h1234);

        // exclusive holder supplies; b=7
        op(3, 0, 6'd7, 0, rd, lat);
        chk("R1 reset value b", rd, 22);
        op(1, 0, 6'd7, 0, rd, lat);
        chk("R4 Exclusive holder supplies", last_sup, 1);
        chk("R4 data from Exclusive holder", rd, 22);
        t0 = txn_cnt;
        op(1, 1, 6'd7, 16'h0B0B, rd, lat);
        chk("R4 both Shared after supply (upgrade)", last_cmd, 3);
        op(3, 0, 6'd7, 0, rd, lat);
        chk("R5 reread after upgrade", rd, 16'h0B0B);

        // write miss; d=14
        t0 = txn_cnt;
        op(0, 1, 6'd14, 16'h4444, rd, lat);
        chk("R6 write miss read-for-ownership", last_cmd, 2);
        chk("R6 one transaction", txn_cnt - t0, 1);
        op(1, 0, 6'd14, 0, rd, lat);
        chk("R6 line Modified supplies", last_sup, 1);
        chk("R6 written value", rd, 16'h4444);
        op(3, 1, 6'd14, 16'h5555, rd, lat);
        chk("R6 write miss with sharers", last_cmd, 2);
        op(0, 0, 6'd14, 0, rd, lat);
        chk("R6 sharer invalidated", rd, 16'h5555);
        chk("R6 writer Modified supplies", last_sup, 1);

        // eviction: c=9 shares index with a=5
        t0 = txn_cnt; w0 = wb_cnt;
        op(0, 1, 6'd9, 16'h9999, rd, lat);
        chk("R9 Shared victim silent", wb_cnt - w0, 0);
        chk("R9 single ownership fill", txn_cnt - t0, 1);
        t0 = txn_cnt;
        op(0, 0, 6'd5, 0, rd, lat);
        chk("R9 dirty victim writeback then fill", txn_cnt - t0, 2);
        chk("R9 one writeback", wb_cnt - w0, 1);
        chk("R9 fill is read", last_cmd, 1);
        chk("R12 value after eviction", rd, 16'h1234);
        op(1, 0, 6'd9, 0, rd, lat);
        chk("R11 written-back value in memory", rd, 16'h9999);
        chk("R11 served from memory", last_sup, 0);
        op(2, 0, 6'd16, 0, rd, lat);
        t0 = txn_cnt; w0 = wb_cnt;
        op(2, 0, 6'd32, 0, rd, lat);
        chk("R9 Exclusive victim silent", wb_cnt - w0, 0);
        chk("R9 Exclusive victim one txn", txn_cnt - t0, 1);
        chk("R1 reset value 32", rd, 97);

        // all four ports at once, same address
        own_mask = '0;
        t0 = txn_cnt;
        for (int c = 0; c < N; c++) begin ma[c] = 6'd48; mv[c] = '0; end
        multi('0, ma, mv, mrd);
        for (int c = 0; c < N; c++) chk("R10 concurrent read data", mrd[c], 145);
        chk("R10 every port owned the bus", own_mask, 4'hF);
        chk("R10 one transaction per port", txn_cnt - t0, 4);

        // sweep over 16 hot addresses
        s = 32'h1F2E3D4C;
        for (int it = 0; it < 600; it++) begin
            s = s * 32'd1103515245 + 32'd12345;
            if (it % 10 == 9) begin
                for (int c = 0; c < N; c++) begin
                    s = s * 32'd1103515245 + 32'd12345;
                    ma[c] = s[20] ? {2'b00, s[23:22], 2'(c)} : {2'b00, s[25:22]};
                    mv[c] = s[15:0];
                end
                if (s[28]) begin
                    for (int c = 0; c < N; c++) ma[c] = {2'b00, s[27:26], 2'(c)};
                    multi('1, ma, mv, mrd);
                end else begin
                    multi('0, ma, mv, mrd);
                    for (int c = 0; c < N; c++)
                        chk("R12 concurrent read value", mrd[c], shadow[ma[c]]);
                end
            end else begin
                int c;
                logic [AW-1:0] a;
                c = int'(s[17:16]);
                a = {2'b00, s[25:22]};
                if (s[20]) begin
                    op(c, 1, a, s[15:0], rd, lat);
                end else begin
                    logic [DW-1:0] exp;
                    exp = shadow[a];
                    op(c, 0, a, 0, rd, lat);
                    chk("R12 read returns latest write", rd, exp);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule